// File: doc/BRIEF.md
# Programmable Clock-Output Waveform Generator

This block drives two output pins of a real-time clock from its 32.768 kHz slow clock. Each pin has its own 3-bit source select. The sources are a constant low level, four square waves divided down from the slow clock, two waveforms derived from the alarm flag, and a shared pulse train. The pulse train has a coded period and a coded high time.

A free-running 15-bit divider supplies all of the square waves. One pulse timer serves both pins. A change of either select or of the period code restarts the pulse timer, so a pin never shows a shortened pulse. Every pin level is registered and appears one slow-clock cycle after the inputs that produce it.

Top module: `rtc_wave_out`

## Requirements
- R1: Select code 0 drives the pin low one cycle later, whatever the alarm or the other pin is doing.
- R2: Select codes 1, 2, 3 and 4 give 50 % square waves with periods of 32768, 1024, 512 and 64 cycles. The divider count n is 0 in the first cycle after reset and rises by one each cycle. The pin shown after the edge that consumes count n is high when (n mod period) is at least half the period.
- R3: Select code 6 copies the alarm flag onto the pin with one cycle of delay.
- R4: Each pin has its own toggle state, cleared by reset. Select code 5 inverts that state on each cycle in which the alarm is high and was low in the previous cycle, counted only while that pin has code 5. The pin shows the updated state one cycle later. While no rising alarm edge is seen, the state holds.
- R5: Period code p (0..3) sets a pulse period of 32768 >> p cycles, which is 1 s, 500 ms, 250 ms or 125 ms.
- R6: High-time code h sets the high width to 1024, 512, 128, 32, 16, 4, 1 or 1 cycles for h = 0 to 7. The pulse phase counts 0 to period-1, and a pin with select code 7 is high while the phase is below the width. A change of h takes effect at once and does not restart the timer.
- R7: A change in either select or in the period code, compared with the previous cycle, restarts the pulse. The pin driven in that cycle is low, and the phase is 0 in the next cycle.
- R8: The two pins decode their selects independently, so any pair of codes works together, including both pins on the same code.
- R9: A synchronous active-high reset drives both pins low and zeroes the divider and the pulse phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz slow clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_a | input | 3 | Source select for pin A |
| sel_b | input | 3 | Source select for pin B |
| per_code | input | 2 | Pulse period code |
| high_code | input | 3 | Pulse high-time code |
| alarm | input | 1 | Alarm flag level |
| wave_a | output | 1 | Registered level of pin A |
| wave_b | output | 1 | Registered level of pin B |

## Verification
A divider that is off by one cycle shifts the 512 Hz wave at its next half-period boundary, which comes within 32 cycles. That fault shows long before the 1 Hz wave would reveal it. A pulse phase that fails to restart or wrap shows as a high edge in the wrong cycle within one pulse period. A missing restart shows as a pin that goes high in the cycle a select changes. A toggle state that is lost or shared between the pins shows at the next rising alarm edge. The reference model predicts every pin level on every cycle, so each of these faults is reported in the cycle in which it first reaches a pin.

// File: rtl/rtc_wave_pkg.sv
package rtc_wave_pkg;
  typedef enum logic [2:0] {
    SRC_LOW      = 3'd0,
    SRC_SQ_1HZ   = 3'd1,
    SRC_SQ_32HZ  = 3'd2,
    SRC_SQ_64HZ  = 3'd3,
    SRC_SQ_512HZ = 3'd4,
    SRC_ALM_TOG  = 3'd5,
    SRC_ALM_COPY = 3'd6,
    SRC_PULSE    = 3'd7
  } src_e;

  localparam int NUM_SQ = 4;

  // log2 of the square-wave frequencies for select codes 1..4
  function automatic int sq_log2(input int idx);
    case (idx)
      0:       return 0;
      1:       return 5;
      2:       return 6;
      default: return 9;
    endcase
  endfunction

  // high width in slow-clock cycles, expressed as a right shift of 1024
  function automatic int high_shift(input logic [2:0] code);
    case (code)
      3'd0:    return 0;
      3'd1:    return 1;
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/rtc_wave_div.sv
module rtc_wave_div
  import rtc_wave_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  output logic [NUM_SQ-1:0] sq
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < NUM_SQ; i++) begin : g_tap
    localparam int TAP = DIV_W - 1 - sq_log2(i);
    assign sq[i] = cnt[TAP];
  end

  // R2: the divider advances by exactly one each cycle
  a_r2_div_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/rtc_wave_pulse.sv
module rtc_wave_pulse #(
  parameter int DIV_W = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [1:0] per_code,
  input  logic [2:0] high_code,
  output logic       level
);
  localparam int HI_BASE = 1024;

  logic [DIV_W-1:0] phase;
  logic [DIV_W-1:0] last;
  logic [DIV_W-1:0] width;

  always_comb begin
    last  = {DIV_W{1'b1}} >> per_code;
    width = DIV_W'(HI_BASE >> rtc_wave_pkg::high_shift(high_code));
  end

  always_ff @(posedge clk) begin
    if (rst || restart)    phase <= '0;
    else if (phase == last) phase <= '0;
    else                   phase <= phase + 1'b1;
  end

  assign level = !restart && (phase < width);

  // R7: a restart zeroes the phase for the next cycle
  a_r7_restart_zero: assert property (@(posedge clk) disable iff (rst)
    restart |=> phase == '0);
  // R5: without a restart the phase stays inside the period
  a_r5_in_period: assert property (@(posedge clk) disable iff (rst)
    !restart |-> phase <= last);
  // R7: no pulse level is offered in a restart cycle
  a_r7_no_runt: assert property (@(posedge clk) disable iff (rst)
    restart |-> !level);
endmodule

// File: rtl/rtc_wave_chan.sv
module rtc_wave_chan
  import rtc_wave_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        sel,
  input  logic [NUM_SQ-1:0] sq,
  input  logic              alarm,
  input  logic              rise,
  input  logic              pulse,
  output logic              wave
);
  logic tog;
  logic tog_nxt;
  logic lvl;

  always_comb begin
    tog_nxt = tog ^ (rise && sel == SRC_ALM_TOG);
    case (sel)
      SRC_SQ_1HZ:   lvl = sq[0];
      SRC_SQ_32HZ:  lvl = sq[1];
      SRC_SQ_64HZ:  lvl = sq[2];
      SRC_SQ_512HZ: lvl = sq[3];
      SRC_ALM_TOG:  lvl = tog_nxt;
      SRC_ALM_COPY: lvl = alarm;
      SRC_PULSE:    lvl = pulse;
      default:      lvl = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog  <= 1'b0;
      wave <= 1'b0;
    end else begin
      tog  <= tog_nxt;
      wave <= lvl;
    end
  end

  // R1: code 0 gives a low pin
  a_r1_low: assert property (@(posedge clk) disable iff (rst)
    sel == SRC_LOW |=> !wave);
  // R3: copy mode follows the alarm one cycle later
  a_r3_copy: assert property (@(posedge clk) disable iff (rst)
    sel == SRC_ALM_COPY |=> wave == $past(alarm));
  // R4: without a rising alarm edge the toggle state holds
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(tog));
endmodule

// File: rtl/rtc_wave_out.sv
module rtc_wave_out
  import rtc_wave_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel_a,
  input  logic [2:0] sel_b,
  input  logic [1:0] per_code,
  input  logic [2:0] high_code,
  input  logic       alarm,
  output logic       wave_a,
  output logic       wave_b
);
  localparam int NCH = 2;

  logic [NUM_SQ-1:0] sq;
  logic [2:0]        sel_v [NCH];
  logic [NCH-1:0]    wave_v;
  logic [2:0]        sel_a_q, sel_b_q;
  logic [1:0]        per_q;
  logic              alarm_q;
  logic              rise;
  logic              restart;
  logic              pulse;

  always_ff @(posedge clk) begin
    sel_a_q <= sel_a;
    sel_b_q <= sel_b;
    per_q   <= per_code;
    alarm_q <= rst ? 1'b0 : alarm;
  end

  assign rise    = alarm && !alarm_q;
  assign restart = (sel_a != sel_a_q) || (sel_b != sel_b_q) || (per_code != per_q);
  assign sel_v[0] = sel_a;
  assign sel_v[1] = sel_b;

  rtc_wave_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .sq(sq)
  );

  rtc_wave_pulse #(.DIV_W(DIV_W)) u_pulse (
    .clk(clk), .rst(rst), .restart(restart),
    .per_code(per_code), .high_code(high_code), .level(pulse)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    rtc_wave_chan u_chan (
      .clk(clk), .rst(rst), .sel(sel_v[i]), .sq(sq),
      .alarm(alarm), .rise(rise), .pulse(pulse), .wave(wave_v[i])
    );
  end

  assign wave_a = wave_v[0];
  assign wave_b = wave_v[1];

  // R7: a select change never lets a pulse-mode pin rise
  a_r7_change_low: assert property (@(posedge clk) disable iff (rst)
    (restart && sel_a == SRC_PULSE) |=> !wave_a);
endmodule

// File: tb/rtc_wave_out_bench.sv
module rtc_wave_out_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel_a = 3'd0, sel_b = 3'd0, high_code = 3'd0;
  logic [1:0] per_code = 2'd0;
  logic       alarm = 1'b0;
  logic       wave_a, wave_b;

  int total = 0, bad = 0;
  bit go = 0, done = 0;

  always #2.5 clk = ~clk;

  rtc_wave_out u_rtc_wave_out (
    .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b),
    .per_code(per_code), .high_code(high_code), .alarm(alarm),
    .wave_a(wave_a), .wave_b(wave_b)
  );

  // behavioural reference
  int cnt, ph, alq;
  int tog [2];
  bit expw [2];
  logic [2:0] p0, p1;
  logic [1:0] pp;
  bit in_rst;

  function automatic int hwidth(input int h);
    int w [8] = '{1024, 512, 128, 32, 16, 4, 1, 1};
    return w[h];
  endfunction

  function automatic int sqper(input int s);
    case (s)
      1: return 32768;
      2: return 1024;
      3: return 512;
      default: return 64;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      cnt = 0; ph = 0; alq = 0; tog[0] = 0; tog[1] = 0;
      expw[0] = 0; expw[1] = 0; in_rst = 1;
    end else begin
      bit rise, rs, pl;
      int s;
      in_rst = 0;
      rise = alarm && (alq == 0);
      rs = (sel_a != p0) || (sel_b != p1) || (per_code != pp);
      pl = !rs && (ph < hwidth(high_code));
      for (int c = 0; c < 2; c++) begin
        s = (c == 0) ? sel_a : sel_b;
        case (s)
          0: expw[c] = 0;
          1, 2, 3, 4: expw[c] = (cnt % sqper(s)) >= sqper(s) / 2;
          5: begin if (rise) tog[c] ^= 1; expw[c] = tog[c][0]; end
          6: expw[c] = alarm;
          default: expw[c] = pl;
        endcase
      end
      if (rs || ph + 1 >= (32768 >> per_code)) ph = 0;
      else ph = ph + 1;
      cnt = (cnt + 1) % 32768;
      alq = alarm;
    end
    p0 = sel_a; p1 = sel_b; pp = per_code;
  end

  function automatic string tag(input int s);
    case (s)
      0: return "R1";
      1, 2, 3, 4: return "R2";
      5: return "R4";
      6: return "R3";
      default: return "R5 R6 R7";
    endcase
  endfunction

  always @(negedge clk) begin
    if (go) begin
      for (int c = 0; c < 2; c++) begin
        logic act;
        string t;
        act = (c == 0) ? wave_a : wave_b;
        t = in_rst ? "R9" : tag((c == 0) ? sel_a : sel_b);
        total++;
        if (act !== expw[c]) begin
          bad++;
          $display("FAIL %s R8 pin%0d t=%0t act=%b exp=%b", t, c, $time, act, expw[c]);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apulse(input int hi, input int lo);
    alarm = 1'b1; cyc(hi);
    alarm = 1'b0; cyc(lo);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    @(posedge clk);
    @(negedge clk); go = 1;           // R9 reset state checked here
    cyc(4);
    sel_a = 3'd1; sel_b = 3'd4; rst = 1'b0;  // R2 1 Hz and 512 Hz
    cyc(40000);
    sel_a = 3'd2; sel_b = 3'd3;       // R2 32 Hz and 64 Hz
    cyc(2100);
    sel_a = 3'd6; sel_b = 3'd5;       // R3 copy, R4 toggle
    for (int i = 1; i < 8; i++) apulse(i, 5);
    sel_a = 3'd5;                     // R8 both toggling, own states
    for (int i = 0; i < 6; i++) apulse(1, 1 + i);
    alarm = 1'b1; cyc(10); alarm = 1'b0; cyc(3);  // R4 long high: one flip
    sel_a = 3'd0; sel_b = 3'd6;       // R1 low despite alarm
    for (int i = 0; i < 5; i++) apulse(2, 3);
    sel_a = 3'd7; sel_b = 3'd0; per_code = 2'd3; high_code = 3'd0;  // R5 R6
    cyc(9000);
    high_code = 3'd6; cyc(4500);      // R6 one-cycle width
    high_code = 3'd7; cyc(4500);
    per_code = 2'd2; high_code = 3'd1; cyc(5000);   // R7 period change
    sel_b = 3'd7; cyc(12000);         // R7 select change, R8 same code
    rst = 1'b1; cyc(3); rst = 1'b0;   // R9 mid-run reset
    per_code = 2'd0; high_code = 3'd2; sel_b = 3'd4;
    cyc(34000);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      summary();
      $finish;
    end
  end
endmodule